// File: doc/BRIEF.md
# Asymmetric Multi-Slot Instruction Decoder

This block sits between a fetch queue and the back end of a small pipeline. Each cycle it looks at a window of up to four queued macro-instructions and turns them into a bundle of up to four micro-operations. Each macro-instruction carries an opcode and a count field. The count field is the number of micro-operations the instruction expands to, minus one.

The four decode slots are not equal. Slot 0 can expand an instruction into one to four micro-operations. Slots 1 to 3 accept only single-micro-operation instructions. Where a long expansion sits, and where the first multi-step instruction sits, therefore decides how many instructions leave the window in a cycle. The block reports that number back so the fetch queue can advance. An instruction that needs more than four micro-operations goes to a microcode sequencer. The sequencer produces that instruction's stream one micro-operation per accepted cycle and blocks all other decoding meanwhile.

The decode path is combinational from window to bundle. The sequencer is a two-state machine: `SEQ_IDLE` (decode normally) and `SEQ_STREAM` (emit the long expansion). The transition `SEQ_IDLE -> SEQ_STREAM` is taken when a valid slot-0 instruction has a count field of 4 or more. The transition `SEQ_STREAM -> SEQ_STREAM` is taken on each accepted step that is not the last. The transition `SEQ_STREAM -> SEQ_IDLE` is taken when the last step is accepted.

Top module: `asym_decoder`

## Requirements
- R1: During and right after reset, no lane is valid and `take_cnt` is 0 while the window is empty, and the sequencer starts in its idle state.
- R2: A valid slot-0 instruction with count field c (bits [2:0] of the slot, opcode in bits [10:3]) and c from 0 to 3 fills lanes 0..c. Lane k carries the micro-op value {opcode, k[2:0]}.
- R3: A valid slot-1..3 instruction with count field 0 is appended to the next free lane as {opcode, 3'd0}, keeping program order: lower lanes are older.
- R4: An instruction in slot 1, 2 or 3 whose count field is not 0 ends the group just before it. It is not consumed, so it reaches slot 0 in a later cycle.
- R5: At most four lanes and four instructions are used per cycle. When slot 0's expansion fills the lanes, later slots wait.
- R6: A valid slot-0 instruction with count field c of 4 or more emits nothing and consumes nothing in its first cycle. Then it emits c+1 micro-ops, one per accepted cycle, on lane 0 only, with values {opcode, step} for step 0..c.
- R7: While the sequencer streams, lanes 1 to 3 stay invalid and no other slot is decoded. `take_cnt` is 1 only in the cycle the last step is accepted, and 0 in every other streaming cycle.
- R8: When `out_ready` is low, `take_cnt` is 0. A streaming sequencer holds its current micro-op unchanged.
- R9: Window slots are used only as a contiguous valid run from slot 0. The first invalid slot ends the group, and an invalid slot 0 gives an empty bundle.
- R10: When `out_ready` is high and the sequencer is idle, `take_cnt` equals the number of instructions whose micro-ops appear in the bundle. It is never larger than the number of valid lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_valid | input | 4 | Per-slot valid of the instruction window |
| win_insn | input | 44 | Slot i at bits [11*i+10 : 11*i], as {opcode[7:0], count[2:0]} |
| take_cnt | output | 3 | Instructions consumed from the window this cycle (0 to 4) |
| out_valid | output | 1 | At least one lane of the bundle is valid |
| out_ready | input | 1 | Downstream accepts the bundle this cycle |
| uop_valid | output | 4 | Per-lane valid, always a run from lane 0 |
| uop_data | output | 44 | Lane k at bits [11*k+10 : 11*k], as {opcode, step} |

## Verification
The slot decode is combinational. The bundle and `take_cnt` for a window are therefore due in the same cycle the window is driven. The bench drives inputs on the falling edge and samples one time unit later, before the next rising edge. The sequencer adds registers: the first streamed micro-op appears in the cycle after the entry cycle, and each later step appears one rising edge after the previous step was accepted. The bench steps the clock once per expected micro-op and checks lane 0, the other lanes and `take_cnt` at each step, including a stalled cycle in which the step must not advance.

// File: rtl/dec_pkg.sv
package dec_pkg;

    typedef enum logic [0:0] {
        SEQ_IDLE   = 1'b0,
        SEQ_STREAM = 1'b1
    } seq_state_e;

    // Micro-op value: opcode followed by the expansion step index.
    function automatic logic [15:0] pack_uop16(input logic [7:0] op, input logic [7:0] step);
        return {op, step};
    endfunction

endpackage

// File: rtl/dec_slot_class.sv
module dec_slot_class #(
    parameter int OPW   = 8,
    parameter int CW    = 3,
    parameter int LANES = 4
) (
    input  logic [OPW+CW-1:0] insn,
    output logic [OPW-1:0]    op,
    output logic [CW-1:0]     cnt,
    output logic              simple,
    output logic              micro
);
    always_comb begin
        op     = insn[OPW+CW-1:CW];
        cnt    = insn[CW-1:0];
        simple = (insn[CW-1:0] == '0);
        micro  = (int'(insn[CW-1:0]) >= LANES);
    end
endmodule

// File: rtl/dec_group_pack.sv
module dec_group_pack #(
    parameter int OPW   = 8,
    parameter int CW    = 3,
    parameter int SLOTS = 4,
    parameter int LANES = 4,
    localparam int UOPW = OPW + CW,
    localparam int NW   = $clog2(SLOTS + 1)
) (
    input  logic [SLOTS-1:0]           valid,
    input  logic [SLOTS-1:0][OPW-1:0]  op,
    input  logic [SLOTS-1:0][CW-1:0]   cnt,
    input  logic [SLOTS-1:0]           simple,
    input  logic [SLOTS-1:0]           micro,
    output logic [LANES-1:0]           lane_valid,
    output logic [LANES-1:0][UOPW-1:0] lane_data,
    output logic [NW-1:0]              n_insn
);
    always_comb begin
        int  fill;
        logic stop;
        lane_valid = '0;
        lane_data  = '0;
        n_insn     = '0;
        fill       = 0;
        stop       = 1'b0;
        // Slot 0: the only slot allowed a multi-step expansion.
        if (valid[0] && !micro[0]) begin
            for (int k = 0; k < LANES; k++) begin
                if (k <= int'(cnt[0])) begin
                    lane_valid[k] = 1'b1;
                    lane_data[k]  = {op[0], CW'(k)};
                end
            end
            fill   = int'(cnt[0]) + 1;
            n_insn = NW'(1);
        end else begin
            stop = 1'b1;
        end
        // Slots 1..: single-step only; anything else closes the group.
        for (int i = 1; i < SLOTS; i++) begin
            if (!stop) begin
                if (valid[i] && simple[i] && (fill < LANES)) begin
                    for (int k = 0; k < LANES; k++) begin
                        if (k == fill) begin
                            lane_valid[k] = 1'b1;
                            lane_data[k]  = {op[i], CW'(0)};
                        end
                    end
                    fill   = fill + 1;
                    n_insn = n_insn + NW'(1);
                end else begin
                    stop = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dec_useq.sv
module dec_useq
    import dec_pkg::*;
#(
    parameter int OPW = 8,
    parameter int CW  = 3,
    localparam int UOPW = OPW + CW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [OPW-1:0]  start_op,
    input  logic [CW-1:0]   start_cnt,
    input  logic            out_ready,
    output logic            busy,
    output logic            done,
    output logic [UOPW-1:0] uop
);
    seq_state_e     state_q, state_d;
    logic [OPW-1:0] op_q;
    logic [CW-1:0]  last_q, step_q;
    logic           at_last;

    assign at_last = (step_q == last_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:   if (start) state_d = SEQ_STREAM;
            SEQ_STREAM: if (out_ready && at_last) state_d = SEQ_IDLE;
            default:    state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= '0;
            last_q <= '0;
            step_q <= '0;
        end else if (state_q == SEQ_IDLE && start) begin
            op_q   <= start_op;
            last_q <= start_cnt;
            step_q <= '0;
        end else if (state_q == SEQ_STREAM && out_ready) begin
            step_q <= step_q + CW'(1);
        end
    end

    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        uop  = '0;
        unique case (state_q)
            SEQ_IDLE: ;
            SEQ_STREAM: begin
                busy = 1'b1;
                done = out_ready && at_last;
                uop  = {op_q, step_q};
            end
            default: ;
        endcase
    end

    AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !out_ready) |=> (busy && $stable(uop))); // R8
    AST_SEQ_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R7
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && out_ready && !done) |=> (busy && uop[CW-1:0] == $past(uop[CW-1:0]) + CW'(1))); // R6
endmodule

// File: rtl/asym_decoder.sv
module asym_decoder #(
    parameter int OPW   = 8,
    parameter int CW    = 3,
    parameter int SLOTS = 4,
    parameter int LANES = 4,
    localparam int IW   = OPW + CW,
    localparam int UOPW = OPW + CW,
    localparam int NW   = $clog2(SLOTS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SLOTS-1:0]      win_valid,
    input  logic [SLOTS*IW-1:0]   win_insn,
    output logic [NW-1:0]         take_cnt,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [LANES-1:0]      uop_valid,
    output logic [LANES*UOPW-1:0] uop_data
);
    logic [SLOTS-1:0][OPW-1:0]  s_op;
    logic [SLOTS-1:0][CW-1:0]   s_cnt;
    logic [SLOTS-1:0]           s_simple, s_micro;
    logic [LANES-1:0]           p_valid;
    logic [LANES-1:0][UOPW-1:0] p_data;
    logic [NW-1:0]              p_n;
    logic                       sq_busy, sq_done, sq_start;
    logic [UOPW-1:0]            sq_uop;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        dec_slot_class #(.OPW(OPW), .CW(CW), .LANES(LANES)) u_class (
            .insn   (win_insn[g*IW +: IW]),
            .op     (s_op[g]),
            .cnt    (s_cnt[g]),
            .simple (s_simple[g]),
            .micro  (s_micro[g])
        );
    end

    dec_group_pack #(.OPW(OPW), .CW(CW), .SLOTS(SLOTS), .LANES(LANES)) u_pack (
        .valid      (win_valid),
        .op         (s_op),
        .cnt        (s_cnt),
        .simple     (s_simple),
        .micro      (s_micro),
        .lane_valid (p_valid),
        .lane_data  (p_data),
        .n_insn     (p_n)
    );

    assign sq_start = win_valid[0] && s_micro[0];

    dec_useq #(.OPW(OPW), .CW(CW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (sq_start),
        .start_op  (s_op[0]),
        .start_cnt (s_cnt[0]),
        .out_ready (out_ready),
        .busy      (sq_busy),
        .done      (sq_done),
        .uop       (sq_uop)
    );

    always_comb begin
        if (sq_busy) begin
            uop_valid            = '0;
            uop_valid[0]         = 1'b1;
            uop_data             = '0;
            uop_data[UOPW-1:0]   = sq_uop;
            take_cnt             = sq_done ? NW'(1) : '0;
        end else begin
            uop_valid = p_valid;
            uop_data  = p_data;
            take_cnt  = out_ready ? p_n : '0;
        end
        out_valid = |uop_valid;
    end

    AST_NO_TAKE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ready |-> (take_cnt == '0)); // R8
    AST_STREAM_SOLO: assert property (@(posedge clk) disable iff (!rst_n)
        sq_busy |-> (uop_valid[LANES-1:1] == '0)); // R7
    AST_LANE_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        ((uop_valid & (uop_valid + LANES'(1))) == '0)); // R9
    AST_TAKE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(take_cnt) <= $countones(uop_valid))); // R10
    AST_ENTRY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!sq_busy && sq_start) |-> (uop_valid == '0 && take_cnt == '0)); // R6
endmodule

// File: tb/asym_decoder_bench.sv
module asym_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    typedef struct packed {
        logic [3:0]       v;
        logic [3:0][10:0] ins;
        logic [3:0]       ev;
        logic [3:0][10:0] eu;
        logic [2:0]       et;
    } vec_t;

    function automatic logic [10:0] w(input logic [7:0] op, input logic [2:0] c);
        return {op, c};
    endfunction

    localparam vec_t VECS [NV] = '{
        '{v:4'hF, ins:{w(8'hD3,0),w(8'hC2,0),w(8'hB1,0),w(8'hA0,0)}, ev:4'hF,
          eu:{w(8'hD3,0),w(8'hC2,0),w(8'hB1,0),w(8'hA0,0)}, et:3'd4},
        '{v:4'hF, ins:{w(8'h14,0),w(8'h13,0),w(8'h12,0),w(8'h11,3)}, ev:4'hF,
          eu:{w(8'h11,3),w(8'h11,2),w(8'h11,1),w(8'h11,0)}, et:3'd1},
        '{v:4'hF, ins:{w(8'h23,0),w(8'h22,0),w(8'h21,0),w(8'h20,1)}, ev:4'hF,
          eu:{w(8'h22,0),w(8'h21,0),w(8'h20,1),w(8'h20,0)}, et:3'd3},
        '{v:4'hF, ins:{w(8'h33,0),w(8'h32,2),w(8'h31,0),w(8'h30,0)}, ev:4'h3,
          eu:{11'd0,11'd0,w(8'h31,0),w(8'h30,0)}, et:3'd2},
        '{v:4'hF, ins:{w(8'h43,0),w(8'h42,0),w(8'h41,1),w(8'h40,0)}, ev:4'h1,
          eu:{11'd0,11'd0,11'd0,w(8'h40,0)}, et:3'd1},
        '{v:4'h7, ins:{w(8'h53,0),w(8'h52,0),w(8'h51,0),w(8'h50,2)}, ev:4'hF,
          eu:{w(8'h51,0),w(8'h50,2),w(8'h50,1),w(8'h50,0)}, et:3'd2},
        '{v:4'h3, ins:{w(8'h63,0),w(8'h62,0),w(8'h61,0),w(8'h60,0)}, ev:4'h3,
          eu:{11'd0,11'd0,w(8'h61,0),w(8'h60,0)}, et:3'd2},
        '{v:4'h0, ins:{w(8'h83,0),w(8'h82,0),w(8'h81,0),w(8'h80,0)}, ev:4'h0,
          eu:{11'd0,11'd0,11'd0,11'd0}, et:3'd0},
        '{v:4'h5, ins:{w(8'h93,0),w(8'h92,0),w(8'h91,0),w(8'h90,0)}, ev:4'h1,
          eu:{11'd0,11'd0,11'd0,w(8'h90,0)}, et:3'd1},
        '{v:4'hF, ins:{w(8'hA3,0),w(8'hA2,0),w(8'hA1,5),w(8'h70,0)}, ev:4'h1,
          eu:{11'd0,11'd0,11'd0,w(8'h70,0)}, et:3'd1}
    };
    localparam string VREQ [NV] = '{"R3", "R5", "R5", "R4", "R4", "R2", "R9", "R9", "R9", "R4"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  win_valid = '0;
    logic [43:0] win_insn = '0;
    logic [2:0]  take_cnt;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [3:0]  uop_valid;
    logic [43:0] uop_data;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    asym_decoder u_asym_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_valid (win_valid),
        .win_insn  (win_insn),
        .take_cnt  (take_cnt),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .uop_valid (uop_valid),
        .uop_data  (uop_data)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Drive a long instruction in slot 0 and follow its stream (R6, R7, R8).
    task automatic run_micro(input logic [7:0] op, input logic [2:0] c, input int stall_at);
        @(negedge clk);
        out_ready = 1'b1;
        win_valid = 4'h3;
        win_insn  = {w(8'hEE,0), w(8'hEF,0), w(8'h01,0), w(op,c)};
        #1;
        chk(uop_valid == 4'h0, "R6", "entry lanes", 64'(uop_valid), 64'h0);
        chk(take_cnt == 3'd0, "R6", "entry take", 64'(take_cnt), 64'h0);
        for (int s = 0; s <= int'(c); s++) begin
            if (s == stall_at) begin
                @(negedge clk);
                out_ready = 1'b0;
                #1;
                chk(uop_data[10:0] == w(op, 3'(s)), "R8", "stalled uop", 64'(uop_data[10:0]), 64'(w(op,3'(s))));
                chk(take_cnt == 3'd0, "R8", "stalled take", 64'(take_cnt), 64'h0);
            end
            @(negedge clk);
            out_ready = 1'b1;
            #1;
            chk(uop_valid == 4'h1, "R7", "stream lanes", 64'(uop_valid), 64'h1);
            chk(uop_data[10:0] == w(op, 3'(s)), "R6", "stream uop", 64'(uop_data[10:0]), 64'(w(op,3'(s))));
            chk(take_cnt == ((s == int'(c)) ? 3'd1 : 3'd0), "R7", "stream take",
                64'(take_cnt), (s == int'(c)) ? 64'h1 : 64'h0);
        end
        // Fetch advances by one: former slot 1 now sits in slot 0.
        @(negedge clk);
        win_valid = 4'h1;
        win_insn  = {33'd0, w(8'h01,0)};
        #1;
        chk(uop_valid == 4'h1 && uop_data[10:0] == w(8'h01,0), "R7", "after stream",
            64'(uop_data[10:0]), 64'(w(8'h01,0)));
        chk(take_cnt == 3'd1, "R10", "after stream take", 64'(take_cnt), 64'h1);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        #1;
        chk(uop_valid == 4'h0 && out_valid == 1'b0, "R1", "reset lanes", 64'(uop_valid), 64'h0);
        chk(take_cnt == 3'd0, "R1", "reset take", 64'(take_cnt), 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(uop_valid == 4'h0, "R1", "post-reset lanes", 64'(uop_valid), 64'h0);

        // Table walk, out_ready high (R2 R3 R4 R5 R9 R10)
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            out_ready = 1'b1;
            win_valid = VECS[i].v;
            win_insn  = VECS[i].ins;
            #1;
            chk(uop_valid == VECS[i].ev, VREQ[i], $sformatf("vec %0d lanes", i),
                64'(uop_valid), 64'(VECS[i].ev));
            for (int k = 0; k < 4; k++) begin
                if (VECS[i].ev[k])
                    chk(uop_data[k*11 +: 11] == VECS[i].eu[k], VREQ[i],
                        $sformatf("vec %0d lane %0d", i, k),
                        64'(uop_data[k*11 +: 11]), 64'(VECS[i].eu[k]));
            end
            chk(take_cnt == VECS[i].et, "R10", $sformatf("vec %0d take", i),
                64'(take_cnt), 64'(VECS[i].et));
        end

        // R8: stall on the decode path
        @(negedge clk);
        out_ready = 1'b0;
        win_valid = VECS[0].v;
        win_insn  = VECS[0].ins;
        #1;
        chk(take_cnt == 3'd0, "R8", "stall take", 64'(take_cnt), 64'h0);
        chk(uop_valid == 4'hF, "R8", "stall lanes", 64'(uop_valid), 64'hF);

        // R6/R7: smallest long expansion, then the largest with a stall
        run_micro(8'h9C, 3'd4, 99);
        run_micro(8'h5A, 3'd7, 3);

        @(negedge clk);
        win_valid = 4'h0;
        finish_run();
    end
endmodule